// File: doc/BRIEF.md
# Character Glyph Streamer for a Character-Cell Display

This block feeds a character-cell display with font bytes, one character at a time. After a synchronous reset it writes a short fixed list of setup commands to the display. It then waits for a character code on a valid/ready input. For each accepted code it does three things. It writes a cursor command that places the character. It points an address counter at the glyph of that code, which is the code times eight. It then writes the eight glyph bytes of that character, one per strobe cycle, from an internal synchronous font memory.

Every display write takes one strobe cycle of `ECYCLE` system clocks. The strobe is produced by a phase counter inside the block. The register-select line marks each write as a command or as glyph data. The read/write line is driven low at all times. A small byte counter counts the eight glyph bytes of a character. When it reaches its terminal count, both counters stop and the block returns to waiting for the next code.

Top module: `glyph_lcd_streamer`

## Requirements
- R1: A synchronous reset drives `lcd_e` low, `in_ready` low and `lcd_rw` low. It restarts the setup sequence and returns the cursor to column 0, line 0, even when applied in the middle of a character.
- R2: After reset, before `in_ready` first rises, exactly four command writes (`lcd_rs`=0) are made, carrying 0x38, 0x0C, 0x06 and 0x01 in that order.
- R3: `in_ready` is high only while the block waits for a code, and a code is taken only on a cycle with `in_valid` and `in_ready` both high. `in_valid` offered while `in_ready` is low changes neither the bytes written nor the number of writes.
- R4: Each accepted code first gives one command write (`lcd_rs`=0) of value 0x80 | (line << 6) | column. The k-th character since reset (counting from 0) has column k mod COLS and line (k / COLS) mod LINES.
- R5: The command write is followed by eight data writes (`lcd_rs`=1). These carry the font bytes at addresses code*8 to code*8+7, in ascending order.
- R6: The font memory byte at address a (11 bits: code in bits 10..3, row in bits 2..0) is (code + 37*row) mod 256.
- R7: Back-to-back writes start `ECYCLE` clocks apart. `lcd_e` rises `ECYCLE`/8 clocks into a write and stays high for exactly `ECYCLE`/2 clocks.
- R8: `lcd_data` and `lcd_rs` do not change while `lcd_e` is high, nor on the clock in which `lcd_e` falls.
- R9: `lcd_rw` is always 0.
- R10: Each character makes exactly nine strobes. After the eighth data write, `lcd_e` stays low and no write happens until a new code is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character code is offered |
| in_code | input | 8 | Character code |
| in_ready | output | 1 | The block is waiting for a code |
| lcd_rs | output | 1 | Register select: 0 command, 1 glyph data |
| lcd_rw | output | 1 | Read/write select, held at 0 (write) |
| lcd_e | output | 1 | Write strobe |
| lcd_data | output | 8 | Byte written to the display |

## Verification
The assertions assume that reset is synchronous and lasts at least one clock edge, and that `in_valid` and `in_code` change only between clock edges. The bench meets both by driving every input on the falling clock edge. The assertions place no rule on how long `in_valid` is held. The stimulus therefore deliberately holds `in_valid` high while the block is busy, with a different code, to show that such offers are ignored. It also raises reset partway through a character.

// File: rtl/glyph_lcd_pkg.sv
package glyph_lcd_pkg;

   typedef enum logic [1:0] {
      ST_SETUP,
      ST_WAIT,
      ST_PLACE,
      ST_GLYPH
   } seq_state_t;

   localparam int SETUP_LEN = 4;

   // Display setup commands: 8-bit bus with two lines, display on,
   // cursor advances to the right, clear.
   function automatic logic [7:0] setup_cmd(input logic [1:0] idx);
      logic [7:0] v;
      case (idx)
         2'd0:    v = 8'h38;
         2'd1:    v = 8'h0C;
         2'd2:    v = 8'h06;
         default: v = 8'h01;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/lcd_strobe_timer.sv
module lcd_strobe_timer #(
   parameter int ECYCLE = 80
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic beat_end,
   output logic strobe
);
   localparam int PH_W    = $clog2(ECYCLE);
   localparam int E_SETUP = ECYCLE / 8;
   localparam int E_HIGH  = ECYCLE / 2;

   logic [PH_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         phase <= '0;
      end else if (phase == PH_W'(ECYCLE - 1)) begin
         phase <= '0;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   assign beat_end = run && (phase == PH_W'(ECYCLE - 1));
   assign strobe   = run && (phase >= PH_W'(E_SETUP)) && (phase < PH_W'(E_SETUP + E_HIGH));

endmodule

// File: rtl/glyph_addr_counter.sv
module glyph_addr_counter #(
   parameter int CODE_W    = 8,
   parameter int ROWS_LOG2 = 3
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          load,
   input  logic [CODE_W-1:0]             code,
   input  logic                          step,
   output logic [CODE_W+ROWS_LOG2-1:0]   addr,
   output logic                          tc
);
   localparam int ADDR_W = CODE_W + ROWS_LOG2;

   logic [ROWS_LOG2-1:0] row_cnt;

   assign tc = (row_cnt == {ROWS_LOG2{1'b1}});

   // Address counter: loads code * 2**ROWS_LOG2, then increments.
   always_ff @(posedge clk) begin
      if (rst) begin
         addr <= '0;
      end else if (load) begin
         addr <= {code, {ROWS_LOG2{1'b0}}};
      end else if (step && !tc) begin
         addr <= addr + ADDR_W'(1);
      end
   end

   // Byte counter: its terminal count holds both counters.
   always_ff @(posedge clk) begin
      if (rst || load) begin
         row_cnt <= '0;
      end else if (step && !tc) begin
         row_cnt <= row_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/glyph_font_rom.sv
module glyph_font_rom #(
   parameter int CODE_W    = 8,
   parameter int ROWS_LOG2 = 3,
   parameter int DATA_W    = 8
) (
   input  logic                          clk,
   input  logic [CODE_W+ROWS_LOG2-1:0]   addr,
   output logic [DATA_W-1:0]             q
);
   localparam int ADDR_W = CODE_W + ROWS_LOG2;

   logic [CODE_W-1:0]    a_code;
   logic [ROWS_LOG2-1:0] a_row;
   logic [DATA_W-1:0]    font_byte;

   assign a_code    = addr[ADDR_W-1:ROWS_LOG2];
   assign a_row     = addr[ROWS_LOG2-1:0];
   assign font_byte = DATA_W'(a_code) + DATA_W'(a_row * 6'd37);

   always_ff @(posedge clk) begin
      q <= font_byte;
   end

endmodule

// File: rtl/glyph_lcd_streamer.sv
module glyph_lcd_streamer
   import glyph_lcd_pkg::*;
#(
   parameter int CODE_W    = 8,
   parameter int ROWS_LOG2 = 3,
   parameter int DATA_W    = 8,
   parameter int ECYCLE    = 80,
   parameter int COLS      = 16,
   parameter int LINES     = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   output logic              in_ready,
   output logic              lcd_rs,
   output logic              lcd_rw,
   output logic              lcd_e,
   output logic [DATA_W-1:0] lcd_data
);
   localparam int ADDR_W = CODE_W + ROWS_LOG2;
   localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int IDX_W  = $clog2(SETUP_LEN);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("glyph_lcd_streamer: DATA_W must be 8");
      end
      if (ECYCLE < 16) begin : g_bad_ecycle
         $error("glyph_lcd_streamer: ECYCLE must be at least 16");
      end
      if (COLS < 1 || COLS > 64) begin : g_bad_cols
         $error("glyph_lcd_streamer: COLS must be 1..64");
      end
      if (LINES < 1 || LINES > 2) begin : g_bad_lines
         $error("glyph_lcd_streamer: LINES must be 1 or 2");
      end
      if (ROWS_LOG2 < 1) begin : g_bad_rows
         $error("glyph_lcd_streamer: ROWS_LOG2 must be at least 1");
      end
   endgenerate

   seq_state_t        state;
   logic [IDX_W-1:0]  setup_idx;
   logic [CODE_W-1:0] code_q;
   logic [COL_W-1:0]  col_q;
   logic              line_q;
   logic              beat_end;
   logic              tc;
   logic [ADDR_W-1:0] rom_addr;
   logic [DATA_W-1:0] rom_q;
   logic              advance;
   logic              col_wrap;
   logic [7:0]        place_cmd;

   assign advance  = (state == ST_GLYPH) && beat_end && tc;
   assign col_wrap = advance && (col_q == COL_W'(COLS - 1));

   lcd_strobe_timer #(.ECYCLE(ECYCLE)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .run      (state != ST_WAIT),
      .beat_end (beat_end),
      .strobe   (lcd_e)
   );

   glyph_addr_counter #(.CODE_W(CODE_W), .ROWS_LOG2(ROWS_LOG2)) u_addr (
      .clk  (clk),
      .rst  (rst),
      .load (state == ST_PLACE),
      .code (code_q),
      .step ((state == ST_GLYPH) && beat_end),
      .addr (rom_addr),
      .tc   (tc)
   );

   glyph_font_rom #(.CODE_W(CODE_W), .ROWS_LOG2(ROWS_LOG2), .DATA_W(DATA_W)) u_rom (
      .clk  (clk),
      .addr (rom_addr),
      .q    (rom_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_SETUP;
         setup_idx <= '0;
         code_q    <= '0;
      end else begin
         case (state)
            ST_SETUP: if (beat_end) begin
               if (setup_idx == IDX_W'(SETUP_LEN - 1)) state <= ST_WAIT;
               else setup_idx <= setup_idx + 1'b1;
            end
            ST_WAIT: if (in_valid) begin
               code_q <= in_code;
               state  <= ST_PLACE;
            end
            ST_PLACE: if (beat_end) state <= ST_GLYPH;
            default:  if (advance) state <= ST_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q <= '0;
      end else if (advance) begin
         col_q <= col_wrap ? '0 : col_q + 1'b1;
      end
   end

   generate
      if (LINES == 2) begin : g_two_lines
         always_ff @(posedge clk) begin
            if (rst) line_q <= 1'b0;
            else if (col_wrap) line_q <= ~line_q;
         end
      end else begin : g_one_line
         assign line_q = 1'b0;
      end
   endgenerate

   assign place_cmd = 8'h80 | {1'b0, line_q, 6'(col_q)};

   always_comb begin
      case (state)
         ST_SETUP: lcd_data = setup_cmd(2'(setup_idx));
         ST_GLYPH: lcd_data = rom_q;
         default:  lcd_data = place_cmd;
      endcase
   end

   assign lcd_rs   = (state == ST_GLYPH);
   assign lcd_rw   = 1'b0;
   assign in_ready = (state == ST_WAIT);

endmodule

// File: rtl/glyph_lcd_chk.sv
module glyph_lcd_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              lcd_rs,
   input logic              lcd_rw,
   input logic              lcd_e,
   input logic [DATA_W-1:0] lcd_data
);
   assert_rw_low_R9: assert property (@(posedge clk) disable iff (rst)
      !lcd_rw);

   assert_wait_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> !lcd_e);

   assert_accept_drops_ready_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   assert_hold_while_strobe_R8: assert property (@(posedge clk) disable iff (rst)
      $past(lcd_e) |-> ($stable(lcd_data) && $stable(lcd_rs)));

   assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(lcd_e) |=> lcd_e);

endmodule

bind glyph_lcd_streamer glyph_lcd_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .lcd_rs   (lcd_rs),
   .lcd_rw   (lcd_rw),
   .lcd_e    (lcd_e),
   .lcd_data (lcd_data)
);

// File: tb/glyph_lcd_streamer_tb.sv
module glyph_lcd_streamer_tb;
   localparam int EC    = 16;
   localparam int HI    = EC / 2;
   localparam int COLS  = 16;
   localparam int LINES = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_code = 8'h00;
   logic       in_ready, lcd_rs, lcd_rw, lcd_e;
   logic [7:0] lcd_data;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   glyph_lcd_streamer #(.ECYCLE(EC), .COLS(COLS), .LINES(LINES)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
      .in_ready(in_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
      .lcd_e(lcd_e), .lcd_data(lcd_data)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Strobe monitor: records every write at the rising strobe.
   logic [7:0] cap_d  [0:4095];
   logic       cap_rs [0:4095];
   int         cap_n = 0;
   int         cyc = 0, last_rise = 0, hi_cnt = 0;
   bit         e_prev = 0, gap = 1;
   logic [7:0] d_prev = 0;
   logic       rs_prev = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         e_prev = 0;
         gap    = 1;
      end else begin
         if (in_ready) gap = 1;
         if (lcd_e && !e_prev) begin
            if (cap_n < 4096) begin
               cap_d[cap_n]  = lcd_data;
               cap_rs[cap_n] = lcd_rs;
            end
            cap_n++;
            if (!gap) check(cyc - last_rise == EC, "R7 strobe period", cyc - last_rise, EC);
            check(lcd_rw == 1'b0, "R9 rw held low", int'(lcd_rw), 0);
            last_rise = cyc;
            gap       = 0;
            hi_cnt    = 1;
         end else if (lcd_e) begin
            hi_cnt++;
            if (lcd_data != d_prev || lcd_rs != rs_prev)
               check(0, "R8 data/rs moved while strobe high", int'(lcd_data), int'(d_prev));
         end else if (e_prev) begin
            check(hi_cnt == HI, "R7 strobe high width", hi_cnt, HI);
            check(lcd_data == d_prev && lcd_rs == rs_prev, "R8 hold at strobe fall",
                  int'(lcd_data), int'(d_prev));
         end
         e_prev  = lcd_e;
         d_prev  = lcd_data;
         rs_prev = lcd_rs;
      end
   end

   function automatic int setup_exp(input int i);
      case (i)
         0: return 'h38;
         1: return 'h0C;
         2: return 'h06;
         default: return 'h01;
      endcase
   endfunction

   task automatic wait_ready();
      do @(negedge clk); while (!in_ready);
   endtask

   task automatic check_setup(input int base);
      check(cap_n - base == 4, "R2 setup write count", cap_n - base, 4);
      for (int i = 0; i < 4; i++) begin
         check(int'(cap_d[base + i]) == setup_exp(i), "R2 setup byte",
               int'(cap_d[base + i]), setup_exp(i));
         check(cap_rs[base + i] == 1'b0, "R2 setup rs", int'(cap_rs[base + i]), 0);
      end
   endtask

   task automatic send_char(input int code, input int k, input bit poke);
      int base, pos_exp, g_exp;
      wait_ready();
      base     = cap_n;
      in_valid = 1'b1;
      in_code  = 8'(code);
      @(negedge clk);
      in_valid = 1'b0;
      check(in_ready == 1'b0, "R3 ready drops after accept", int'(in_ready), 0);
      if (poke) begin
         repeat (10) @(negedge clk);
         in_valid = 1'b1;
         in_code  = ~8'(code);
         repeat (30) @(negedge clk);
         in_valid = 1'b0;
      end
      wait_ready();
      check(cap_n - base == 9, "R10 R3 nine writes per character", cap_n - base, 9);
      pos_exp = 'h80 | ((((k / COLS) % LINES) & 1) << 6) | (k % COLS);
      check(int'(cap_d[base]) == pos_exp, "R4 cursor command", int'(cap_d[base]), pos_exp);
      check(cap_rs[base] == 1'b0, "R4 cursor command rs", int'(cap_rs[base]), 0);
      for (int r = 0; r < 8; r++) begin
         g_exp = (code + 37 * r) % 256;
         check(int'(cap_d[base + 1 + r]) == g_exp, "R5 R6 glyph byte",
               int'(cap_d[base + 1 + r]), g_exp);
         check(cap_rs[base + 1 + r] == 1'b1, "R5 glyph rs", int'(cap_rs[base + 1 + r]), 1);
      end
      base = cap_n;
      repeat (3 * EC) @(negedge clk);
      check(cap_n == base && !lcd_e, "R10 quiet while waiting", cap_n - base, 0);
   endtask

   initial begin
      int base;
      repeat (4) @(negedge clk);
      check(lcd_e == 1'b0, "R1 strobe low in reset", int'(lcd_e), 0);
      check(in_ready == 1'b0, "R1 ready low in reset", int'(in_ready), 0);
      check(lcd_rw == 1'b0, "R1 R9 rw low in reset", int'(lcd_rw), 0);
      rst = 1'b0;
      wait_ready();
      check_setup(0);

      for (int c = 0; c < 256; c++) send_char(c, c, (c % 17) == 0);

      // Reset in the middle of a character.
      wait_ready();
      in_valid = 1'b1;
      in_code  = 8'h55;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (50) @(negedge clk);
      rst  = 1'b1;
      base = cap_n;
      repeat (3) @(negedge clk);
      check(lcd_e == 1'b0, "R1 strobe low after mid reset", int'(lcd_e), 0);
      check(in_ready == 1'b0, "R1 ready low after mid reset", int'(in_ready), 0);
      rst = 1'b0;
      wait_ready();
      check_setup(base);
      send_char('h41, 0, 1'b0);   // R1: cursor restarts at column 0, line 0
      send_char('h42, 1, 1'b0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog R10 actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule